// File: doc/BRIEF.md
# Satellite Spreading-Code Generator (1023-chip Gold sequence)

This block produces the 1023-chip coarse ranging code of one satellite from a fast reference clock. An integer divider turns the reference clock into a one-cycle chip enable. Two 10-stage maximal-length shift registers advance on that enable. A phase selector XORs two stages of the second register, which gives a delayed copy of its sequence. The output chip is the last stage of the first register XORed with that delayed copy.

A chip counter marks the last chip of every code period with an epoch strobe, which is 1 kHz at the default rates. A second divider turns the epochs into a square-wave data-bit clock. An external resync strobe restarts the whole block at chip zero: both registers go to all ones, the counters clear and the divider phase clears. The two 4-bit tap indices choose the satellite.

Top module: `gold_code_gen`

## Requirements
- R1: `chip_en_o` is a single-cycle pulse exactly every `REF_DIV` clock cycles (default 10). After reset release or after a resync, the first pulse comes `REF_DIV` cycles after the divider phase is cleared. It is low during reset.
- R2: After reset, both registers hold all ones. With tap indices (2,6), the first ten chips in order are 1,1,0,0,1,0,0,0,0,0 (octal 1440).
- R3: The chip sequence repeats exactly: chip k equals chip k+1023.
- R4: `epoch_o` is high only in the cycle of the `chip_en_o` pulse that carries chip index 1022 (the last chip of a period). It is low in every other cycle and during reset.
- R5: `data_clk_o` is 1 after reset or resync. It changes level only on the clock edge that follows an epoch pulse: high for `DATA_DIV/2` code periods, then low for `DATA_DIV/2` code periods, with a default of 20 periods in total.
- R6: A one-cycle `resync_i` loads both registers with all ones and clears the chip counter, the data-clock counter and the divider phase. The chips that follow repeat the sequence from chip 0.
- R7: Each chip equals G1 stage 10 XOR G2 stage `tap_a_i` XOR G2 stage `tap_b_i`. The G1 feedback is stage 3 XOR stage 10. The G2 feedback is the XOR of stages 2, 3, 6, 8, 9 and 10. Stage 1 takes the feedback, and stage n+1 takes stage n.
- R8: A tap index outside 1..10 (for example 0 or 12) contributes 0 to the XOR in R7.
- R9: `chip_o` changes only on the edge following a `chip_en_o` pulse, on a resync, or when a tap index changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (10.23 MHz at default rates) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| resync_i | input | 1 | Synchronous restart strobe to chip 0 |
| tap_a_i | input | 4 | First G2 stage index for the delayed copy |
| tap_b_i | input | 4 | Second G2 stage index for the delayed copy |
| chip_o | output | 1 | Current code chip |
| chip_en_o | output | 1 | One-cycle pulse at chip rate; the chip advances after it |
| epoch_o | output | 1 | Pulse marking the last chip of a code period |
| data_clk_o | output | 1 | Square-wave data-bit clock, one cycle per DATA_DIV periods |

## Verification
A wrong feedback or tap bit in either register corrupts `chip_o` within the first few chips, and the bench catches it there because its own register model is compared on every chip. A wrong chip-counter limit moves `epoch_o` away from index 1022 at the end of the first code period, which is 1023 chips. A data-divider fault shows on `data_clk_o` only after ten periods. A divider-phase fault shows at the very first chip-enable pulse.

// File: rtl/gold_pkg.sv
package gold_pkg;
  // shift register length and natural code length
  localparam int unsigned STAGES   = 10;
  localparam int unsigned CODE_LEN = (1 << STAGES) - 1;
  // feedback masks, bit i stands for stage i+1
  localparam logic [STAGES-1:0] G1_FB_MASK = 10'h204; // stages 3,10
  localparam logic [STAGES-1:0] G2_FB_MASK = 10'h3A6; // stages 2,3,6,8,9,10
  localparam logic [STAGES-1:0] SEED       = '1;
  localparam int unsigned TAP_W = 4;
endpackage

// File: rtl/chip_tick.sv
module chip_tick #(
  parameter int unsigned REF_DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic tick_o
);
  localparam int unsigned DW = $clog2(REF_DIV + 1);
  localparam logic [DW-1:0] LAST = DW'(REF_DIV - 1);

  logic [DW-1:0] div_q, div_d;

  always_comb begin
    tick_o = (div_q == LAST);
    if (sync_i)      div_d = '0;
    else if (tick_o) div_d = '0;
    else             div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end
endmodule

// File: rtl/gold_lfsr.sv
module gold_lfsr #(
  parameter int unsigned           N       = 10,
  parameter logic [N-1:0]          FB_MASK = '0,
  parameter logic [N-1:0]          SEED    = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         adv_i,
  output logic [N-1:0] state_o
);
  logic [N-1:0] sr_q, sr_d;
  logic         fb;

  always_comb begin
    fb = ^(sr_q & FB_MASK);
    if (load_i)     sr_d = SEED;
    else if (adv_i) sr_d = {sr_q[N-2:0], fb};
    else            sr_d = sr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= SEED;
    else         sr_q <= sr_d;
  end

  assign state_o = sr_q;
endmodule

// File: rtl/phase_tap.sv
module phase_tap #(
  parameter int unsigned N     = 10,
  parameter int unsigned TAP_W = 4
) (
  input  logic [N-1:0]     state_i,
  input  logic [TAP_W-1:0] sel_a_i,
  input  logic [TAP_W-1:0] sel_b_i,
  output logic             tap_o
);
  logic [N-1:0] hit_a, hit_b;

  // one comparator per stage; an index outside 1..N matches nothing
  for (genvar i = 0; i < N; i++) begin : g_stage
    assign hit_a[i] = (sel_a_i == TAP_W'(i + 1)) & state_i[i];
    assign hit_b[i] = (sel_b_i == TAP_W'(i + 1)) & state_i[i];
  end

  assign tap_o = (|hit_a) ^ (|hit_b);
endmodule

// File: rtl/epoch_timer.sv
module epoch_timer #(
  parameter int unsigned CODE_LEN = 1023,
  parameter int unsigned DATA_DIV = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic tick_i,
  output logic epoch_o,
  output logic data_clk_o
);
  localparam int unsigned CW   = $clog2(CODE_LEN);
  localparam int unsigned BW   = $clog2(DATA_DIV + 1);
  localparam logic [CW-1:0] C_LAST = CW'(CODE_LEN - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DATA_DIV - 1);
  localparam logic [BW-1:0] B_HALF = BW'(DATA_DIV / 2);

  logic [CW-1:0] chip_q, chip_d;
  logic [BW-1:0] bit_q, bit_d;

  always_comb begin
    epoch_o = tick_i & (chip_q == C_LAST);
    if (sync_i)       chip_d = '0;
    else if (epoch_o) chip_d = '0;
    else if (tick_i)  chip_d = chip_q + 1'b1;
    else              chip_d = chip_q;

    if (sync_i)       bit_d = '0;
    else if (epoch_o) bit_d = (bit_q == B_LAST) ? '0 : bit_q + 1'b1;
    else              bit_d = bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_q <= '0;
      bit_q  <= '0;
    end else begin
      chip_q <= chip_d;
      bit_q  <= bit_d;
    end
  end

  assign data_clk_o = (bit_q < B_HALF);
endmodule

// File: rtl/gold_code_gen.sv
module gold_code_gen
  import gold_pkg::*;
#(
  parameter int unsigned REF_DIV  = 10,
  parameter int unsigned DATA_DIV = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             resync_i,
  input  logic [TAP_W-1:0] tap_a_i,
  input  logic [TAP_W-1:0] tap_b_i,
  output logic             chip_o,
  output logic             chip_en_o,
  output logic             epoch_o,
  output logic             data_clk_o
);
  logic              tick;
  logic [STAGES-1:0] g1_state, g2_state;
  logic              g2_delayed;

  chip_tick #(.REF_DIV(REF_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(resync_i), .tick_o(tick)
  );

  gold_lfsr #(.N(STAGES), .FB_MASK(G1_FB_MASK), .SEED(SEED)) u_g1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(resync_i), .adv_i(tick),
    .state_o(g1_state)
  );

  gold_lfsr #(.N(STAGES), .FB_MASK(G2_FB_MASK), .SEED(SEED)) u_g2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(resync_i), .adv_i(tick),
    .state_o(g2_state)
  );

  phase_tap #(.N(STAGES), .TAP_W(TAP_W)) u_sel (
    .state_i(g2_state), .sel_a_i(tap_a_i), .sel_b_i(tap_b_i),
    .tap_o(g2_delayed)
  );

  epoch_timer #(.CODE_LEN(CODE_LEN), .DATA_DIV(DATA_DIV)) u_epoch (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(resync_i), .tick_i(tick),
    .epoch_o(epoch_o), .data_clk_o(data_clk_o)
  );

  assign chip_o    = g1_state[STAGES-1] ^ g2_delayed;
  assign chip_en_o = tick;
endmodule

// File: rtl/gold_code_chk.sv
module gold_code_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       resync_i,
  input logic [3:0] tap_a_i,
  input logic [3:0] tap_b_i,
  input logic       chip_o,
  input logic       chip_en_o,
  input logic       epoch_o,
  input logic       data_clk_o
);
  // R1: enable pulses are isolated single cycles
  a_r1_en_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_en_o |=> !chip_en_o);

  // R4: an epoch only ever coincides with a chip enable
  a_r4_epoch_on_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_o |-> chip_en_o);

  // R5: data clock moves only after an epoch or a resync
  a_r5_data_clk_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_clk_o) |-> ($past(epoch_o) || $past(resync_i)));

  // R6: a resync clears the divider phase, so no enable or epoch follows at once
  a_r6_resync_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> (!chip_en_o && !epoch_o));

  // R9: chip holds between enables while the taps are steady
  a_r9_chip_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chip_en_o && !resync_i) |=>
      ($stable(chip_o) || !$stable(tap_a_i) || !$stable(tap_b_i)));
endmodule

bind gold_code_gen gold_code_chk u_chk (.*);

// File: tb/sim_gold_code_gen.sv
module sim_gold_code_gen;
  localparam int RD = 2;
  localparam int DD = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_ni, resync_i;
  logic [3:0] tap_a_i, tap_b_i;
  logic       chip_o, chip_en_o, epoch_o, data_clk_o;

  gold_code_gen #(.REF_DIV(RD), .DATA_DIV(DD)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .resync_i(resync_i),
    .tap_a_i(tap_a_i), .tap_b_i(tap_b_i), .chip_o(chip_o),
    .chip_en_o(chip_en_o), .epoch_o(epoch_o), .data_clk_o(data_clk_o)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [10:1] m_g1, m_g2;
  int m_idx, m_dcnt, gap, nseq;
  logic seqbuf [0:2045];

  function automatic logic tb_tap(logic [10:1] g, logic [3:0] t);
    int ti = int'(t);
    return (ti >= 1 && ti <= 10) ? g[ti] : 1'b0;
  endfunction

  function automatic logic exp_chip();
    return m_g1[10] ^ tb_tap(m_g2, tap_a_i) ^ tb_tap(m_g2, tap_b_i);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_g1 = '1; m_g2 = '1; m_idx = 0; m_dcnt = 0; gap = 0;
  endtask

  task automatic step(bit rec);
    logic e;
    @(negedge clk);
    gap++;
    e = exp_chip();
    check(data_clk_o == (m_dcnt < DD/2), "R5", "data_clk", data_clk_o, m_dcnt < DD/2);
    if (chip_en_o) begin
      check(chip_o == e, "R7", "chip", chip_o, e);
      check(gap == RD, "R1", "enable spacing", gap, RD);
      check(epoch_o == (m_idx == 1022), "R4", "epoch", epoch_o, m_idx == 1022);
      if (rec && nseq < 2046) begin seqbuf[nseq] = chip_o; nseq++; end
      m_g1 = {m_g1[9:1], m_g1[3] ^ m_g1[10]};
      m_g2 = {m_g2[9:1], m_g2[2] ^ m_g2[3] ^ m_g2[6] ^ m_g2[8] ^ m_g2[9] ^ m_g2[10]};
      if (m_idx == 1022) begin m_idx = 0; m_dcnt = (m_dcnt + 1) % DD; end
      else m_idx++;
      gap = 0;
    end else begin
      check(chip_o == e, "R9", "chip hold", chip_o, e);
      check(epoch_o == 1'b0, "R4", "epoch off", epoch_o, 0);
    end
  endtask

  task automatic run_chips(int n, bit rec);
    int seen = 0;
    while (seen < n) begin
      step(rec);
      if (gap == 0) seen++;
    end
  endtask

  task automatic do_resync(logic [3:0] a, logic [3:0] b);
    tap_a_i = a; tap_b_i = b; resync_i = 1'b1;
    model_reset();
    step(0);   // R6: state sampled here is post-resync
    resync_i = 1'b0;
  endtask

  initial begin
    rst_ni = 1'b0; resync_i = 1'b0; tap_a_i = 4'd2; tap_b_i = 4'd6;
    nseq = 0;
    repeat (3) @(negedge clk);
    check(chip_en_o == 1'b0, "R1", "reset enable", chip_en_o, 0);
    check(epoch_o == 1'b0, "R4", "reset epoch", epoch_o, 0);
    check(data_clk_o == 1'b1, "R5", "reset data_clk", data_clk_o, 1);
    check(chip_o == 1'b1, "R2", "reset chip", chip_o, 1);
    rst_ni = 1'b1;
    model_reset();
    gap = 1;

    // full data-clock period with taps (2,6)
    run_chips(21 * 1023, 1);
    begin
      logic [9:0] first10;
      for (int i = 0; i < 10; i++) first10[9-i] = seqbuf[i];
      check(first10 == 10'o1440, "R2", "first ten chips", first10, 10'o1440);
    end
    begin
      int mism = 0;
      for (int i = 0; i < 1023; i++) if (seqbuf[i] !== seqbuf[i+1023]) mism++;
      check(mism == 0, "R3", "period mismatches", mism, 0);
    end

    // R6: restart mid-stream and recheck the opening chips
    run_chips(500, 0);
    do_resync(4'd2, 4'd6);
    check(data_clk_o == 1'b1, "R6", "data_clk after resync", data_clk_o, 1);
    nseq = 0;
    run_chips(1100, 1);
    begin
      int mism = 0;
      for (int i = 0; i < 1023; i++) if (seqbuf[i] !== seqbuf[i+1023] && i + 1023 < 1100) mism++;
      for (int i = 0; i < 10; i++) if (seqbuf[i] !== ((10'o1440 >> (9-i)) & 1)) mism++;
      check(mism == 0, "R6", "restart sequence", mism, 0);
    end

    // R7 other satellites, R8 out-of-range indices
    do_resync(4'd3, 4'd7);  run_chips(1100, 0);
    do_resync(4'd1, 4'd10); run_chips(1100, 0);
    do_resync(4'd0, 4'd5);  run_chips(1100, 0); // R8
    do_resync(4'd12, 4'd4); run_chips(1100, 0); // R8
    do_resync(4'd0, 4'd15); run_chips(40, 0);   // R8: both out, chip is G1 alone

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule